// File: doc/BRIEF.md
# Quad-Channel Converter Serial Command Decoder

This block is the serial receive front end of a four-channel, 16-bit, double-buffered digital-to-analog converter. A host shifts 24-bit write frames in over a three-wire SPI-style link: a frame strobe, a bit clock and a data line. The block takes in each complete frame and checks its two address bits against the strap pins. It then decodes a load-mode field and a channel field and writes the 16-bit code into that channel's staging register. Depending on the mode, it either stops there, also loads the chosen channel's live register, or loads all four live registers from their staging registers in a single cycle.

The serial inputs are treated as asynchronous. They pass through synchronizers into the system clock domain, and edges are found there, so the bit clock must run several times slower than `clk`. The four live registers leave the block on one flat bus, and every load raises a one-cycle `update_pulse`. A frame that is addressed correctly but carries a reserved mode or a set power-down bit changes nothing and raises `frame_err` for one cycle.

Top module: `quad_dac_cmd_rx`

## Requirements
- R1: A frame begins when `sync_n` falls. While `sync_n` is low, `din` is sampled on each falling edge of `sclk`. The first bit sampled is frame bit 23, and bits are sent most significant first. Frame layout: bits 23:22 address, bits 21:20 load mode, bit 19 ignored, bits 18:17 channel, bit 16 power-down, bits 15:0 code.
- R2: A frame acts only when bits 23:22 equal `addr_strap`. A frame with a different address changes no register and raises neither `update_pulse` nor `frame_err`.
- R3: Load mode 00 writes the code into the selected channel's staging register only. `dac_q` does not change and `update_pulse` stays low.
- R4: Load mode 01 writes the staging register and loads the code into the selected channel's live register. The other live registers keep their values.
- R5: Load mode 10 writes the selected staging register and then copies all four staging registers into the live registers in the same clock cycle. The selected channel receives the new code.
- R6: Channel field 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. Channel i is driven on `dac_q[16*i+15:16*i]`.
- R7: If `sync_n` rises before 24 bits have been sampled, the partial frame is discarded with no effect, and the next frame is received normally.
- R8: An addressed frame with load mode 11, or with bit 16 set, writes nothing and loads nothing. It raises `frame_err` for exactly one cycle.
- R9: `update_pulse` is high for exactly one cycle on each load, and `dac_q` changes only in a cycle where `update_pulse` is high.
- R10: While `rst_n` is low, all staging and live registers are zero and both pulses are low.
- R11: Falling `sclk` edges after the 24th in the same `sync_n` low period are ignored. The frame formed by the first 24 bits takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_strap | input | 2 | Strapped device address |
| sclk | input | 1 | Serial bit clock, idle high, sampled on falling edges |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data, most significant bit first |
| dac_q | output | 64 | Four live 16-bit codes, channel 0 in the low bits |
| update_pulse | output | 1 | One-cycle pulse when any live register is loaded |
| frame_err | output | 1 | One-cycle pulse for an addressed frame with a reserved mode or power-down bit |

## Verification
The hardest case to observe is a staging register whose value differs from its live register. Staging registers have no port of their own, so they can only be seen through a later simultaneous load. The stimulus fills three staging registers with buffer-only frames and confirms that the outputs stay at zero. It then sends a mode 10 frame to the fourth channel and expects all four codes on one update pulse. Later it leaves a single staging register holding a value that differs from its live register before another all-channel load. Short frames, over-long frames and frames for another address are placed between real ones, to show that the shift state recovers and that nothing leaks out.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_BITS = 24;
  localparam int DATA_W     = 16;
  localparam int NUM_CH     = 4;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int ADDR_W     = 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    LM_STAGE_ONLY = 2'b00,
    LM_LOAD_ONE   = 2'b01,
    LM_LOAD_ALL   = 2'b10,
    LM_RESERVED   = 2'b11
  } load_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    load_mode_e        mode;
    logic              spare;
    logic [CH_W-1:0]   chan;
    logic              pwr_dn;
    logic [DATA_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sync_n,
  input  logic din,
  output logic rst_sync_n,
  output logic sclk_fall,
  output logic sync_fall,
  output logic sync_low,
  output logic din_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b110;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic [NSIG-1:0]        raw_in;
  logic [NSIG-1:0]        synced;
  logic                   sclk_prev;
  logic                   sync_prev;

  // reset: asserted at once, released after SYNC_STAGES clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  assign raw_in = {sclk, sync_n, din};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) stg <= {SYNC_STAGES{IDLE_LVL[g]}};
      else             stg <= {stg[SYNC_STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = stg[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_prev <= 1'b1;
      sync_prev <= 1'b1;
    end else begin
      sclk_prev <= synced[2];
      sync_prev <= synced[1];
    end
  end

  assign din_s     = synced[0];
  assign sync_low  = ~synced[1];
  assign sync_fall = sync_prev & ~synced[1];
  assign sclk_fall = sclk_prev & ~synced[2];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_fall,
  input  logic                  sync_fall,
  input  logic                  sync_low,
  input  logic                  din_s,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame_word
);
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  armed_q, armed_d;
  logic                  vld_q, vld_d;
  logic                  shift_en;

  always_comb begin
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    vld_d    = 1'b0;
    shift_en = 1'b0;
    if (sync_fall) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (!sync_low) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (armed_q && sclk_fall) begin
      shift_en = 1'b1;
      shift_d  = {shift_q[FRAME_BITS-2:0], din_s};
      cnt_d    = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
        vld_d   = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (shift_en) shift_q <= shift_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
    end
  end

  assign frame_vld  = vld_q;
  assign frame_word = shift_q;
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
(
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic [ADDR_W-1:0]     addr_strap,
  output logic                  wr_en,
  output logic [CH_W-1:0]       wr_chan,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  load_one,
  output logic                  load_all,
  output logic                  cmd_err
);
  frame_t fr;
  logic   hit;
  logic   bad;
  logic   unused_spare;

  assign fr           = frame_t'(frame_word);
  assign unused_spare = fr.spare;

  always_comb begin
    hit      = frame_vld && (fr.addr == addr_strap);
    bad      = (fr.mode == LM_RESERVED) || fr.pwr_dn;
    cmd_err  = hit && bad;
    wr_en    = hit && !bad;
    load_one = wr_en && (fr.mode == LM_LOAD_ONE);
    load_all = wr_en && (fr.mode == LM_LOAD_ALL);
    wr_chan  = fr.chan;
    wr_data  = fr.code;
  end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_chan,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     load_one,
  input  logic                     load_all,
  input  logic                     cmd_err,
  output logic [NUM_CH*DATA_W-1:0] dac_q,
  output logic                     update_pulse,
  output logic                     frame_err
);
  logic upd_q, err_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              sel;
    logic              stage_en, live_en;
    logic [DATA_W-1:0] stage_q, stage_d;
    logic [DATA_W-1:0] live_q, live_d;

    always_comb begin
      sel      = (wr_chan == CH_W'(i));
      stage_en = wr_en && sel;
      stage_d  = wr_data;
      live_en  = load_all || (load_one && sel);
      live_d   = stage_en ? wr_data : stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (stage_en) stage_q <= stage_d;
        if (live_en)  live_q  <= live_d;
      end
    end

    assign dac_q[i*DATA_W +: DATA_W] = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      upd_q <= load_one || load_all;
      err_q <= cmd_err;
    end
  end

  assign update_pulse = upd_q;
  assign frame_err    = err_q;
endmodule

// File: rtl/quad_dac_cmd_rx.sv
module quad_dac_cmd_rx
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_strap,
  input  logic                     sclk,
  input  logic                     sync_n,
  input  logic                     din,
  output logic [NUM_CH*DATA_W-1:0] dac_q,
  output logic                     update_pulse,
  output logic                     frame_err
);
  logic                  rst_sync_n;
  logic                  sclk_fall, sync_fall, sync_low, din_s;
  logic                  frame_vld;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  wr_en, load_one, load_all, cmd_err;
  logic [CH_W-1:0]       wr_chan;
  logic [DATA_W-1:0]     wr_data;

  qdac_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .sync_n     (sync_n),
    .din        (din),
    .rst_sync_n (rst_sync_n),
    .sclk_fall  (sclk_fall),
    .sync_fall  (sync_fall),
    .sync_low   (sync_low),
    .din_s      (din_s)
  );

  qdac_shifter i_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_fall  (sclk_fall),
    .sync_fall  (sync_fall),
    .sync_low   (sync_low),
    .din_s      (din_s),
    .frame_vld  (frame_vld),
    .frame_word (frame_word)
  );

  qdac_decode i_dec (
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .addr_strap (addr_strap),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_data    (wr_data),
    .load_one   (load_one),
    .load_all   (load_all),
    .cmd_err    (cmd_err)
  );

  qdac_regbank i_bank (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (wr_en),
    .wr_chan      (wr_chan),
    .wr_data      (wr_data),
    .load_one     (load_one),
    .load_all     (load_all),
    .cmd_err      (cmd_err),
    .dac_q        (dac_q),
    .update_pulse (update_pulse),
    .frame_err    (frame_err)
  );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
  import qdac_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_vld,
  input logic [NUM_CH*DATA_W-1:0] dac_q,
  input logic                     update_pulse,
  input logic                     frame_err
);
  // R9
  dac_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> update_pulse);

  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |=> !update_pulse);

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(dac_q) && !update_pulse));

  // R1
  upd_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> $past(frame_vld));

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!update_pulse && !frame_err);
    end
  end
endmodule

bind quad_dac_cmd_rx qdac_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_vld    (frame_vld),
  .dac_q        (dac_q),
  .update_pulse (update_pulse),
  .frame_err    (frame_err)
);

// File: tb/test_quad_dac_cmd_rx.sv
module test_quad_dac_cmd_rx;
  localparam int HALF = 4;

  typedef struct {
    bit          is_err;
    logic [63:0] dac;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr_strap = 2'b00;
  logic        sclk = 1'b1;
  logic        sync_n = 1'b1;
  logic        din = 1'b0;
  logic [63:0] dac_q;
  logic        update_pulse;
  logic        frame_err;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  exp_t        exp_q[$];
  logic [15:0] stage_m [4];
  logic [15:0] live_m [4];

  always #10 clk = ~clk;

  quad_dac_cmd_rx i_quad_dac_cmd_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_strap   (addr_strap),
    .sclk         (sclk),
    .sync_n       (sync_n),
    .din          (din),
    .dac_q        (dac_q),
    .update_pulse (update_pulse),
    .frame_err    (frame_err)
  );

  function automatic logic [63:0] pack_live();
    return {live_m[3], live_m[2], live_m[1], live_m[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // monitor: every pulse must match the next queued expectation
  always @(negedge clk) begin
    if (mon_on && (update_pulse || frame_err)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", {62'd0, update_pulse, frame_err}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(frame_err == e.is_err && update_pulse == !e.is_err,
              {e.tag, " pulse kind"}, {62'd0, update_pulse, frame_err},
              {62'd0, !e.is_err, e.is_err});
        check(dac_q == e.dac, {e.tag, " codes"}, dac_q, e.dac);
      end
    end
  end

  task automatic send_bits(input logic [23:0] word, input int nbits, input int extra);
    @(negedge clk);
    sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits + extra; i++) begin
      din = (i < nbits) ? word[23-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    sync_n = 1'b1;
    din = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_frame(input logic [1:0] a, input logic [1:0] m, input logic [1:0] ch,
                          input logic pd, input logic [15:0] code, input int nbits,
                          input int extra, input string tag);
    logic [23:0] word;
    exp_t e;
    word = {a, m, 1'b0, ch, pd, code};
    if (nbits >= 24 && a == addr_strap) begin
      e.tag = tag;
      if (m == 2'b11 || pd) begin
        e.is_err = 1'b1;
        e.dac = pack_live();
        exp_q.push_back(e);
      end else begin
        stage_m[ch] = code;
        if (m == 2'b01) live_m[ch] = code;
        if (m == 2'b10) for (int k = 0; k < 4; k++) live_m[k] = stage_m[k];
        if (m != 2'b00) begin
          e.is_err = 1'b0;
          e.dac = pack_live();
          exp_q.push_back(e);
        end
      end
    end
    send_bits(word, nbits, extra);
    check(dac_q == pack_live(), {tag, " settled codes"}, dac_q, pack_live());
    check(exp_q.size() == 0, {tag, " expected pulse seen"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic apply_reset(input string tag);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      stage_m[k] = '0;
      live_m[k] = '0;
    end
    repeat (3) @(negedge clk);
    check(dac_q == 64'd0, tag, dac_q, 64'd0);
    check(!update_pulse && !frame_err, tag, {62'd0, update_pulse, frame_err}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    // R10 reset state
    apply_reset("R10 reset");

    // R3 staging-only writes leave outputs at zero
    do_frame(2'b00, 2'b00, 2'b00, 1'b0, 16'h1111, 24, 0, "R3 stage ch0");
    do_frame(2'b00, 2'b00, 2'b01, 1'b0, 16'h2222, 24, 0, "R3 stage ch1");
    do_frame(2'b00, 2'b00, 2'b10, 1'b0, 16'h3333, 24, 0, "R3 stage ch2");
    // R5 load all with new code for ch3
    do_frame(2'b00, 2'b10, 2'b11, 1'b0, 16'h4444, 24, 0, "R5 load all");

    // R4 R6 sequential single-channel loads
    do_frame(2'b00, 2'b01, 2'b00, 1'b0, 16'hA00A, 24, 0, "R4 R6 ch0");
    do_frame(2'b00, 2'b01, 2'b01, 1'b0, 16'hB11B, 24, 0, "R4 R6 ch1");
    do_frame(2'b00, 2'b01, 2'b10, 1'b0, 16'hC22C, 24, 0, "R4 R6 ch2");
    do_frame(2'b00, 2'b01, 2'b11, 1'b0, 16'hD33D, 24, 0, "R4 R6 ch3");

    // R2 address mismatch ignored, then strap change accepted
    do_frame(2'b01, 2'b01, 2'b00, 1'b0, 16'hFFFF, 24, 0, "R2 mismatch");
    addr_strap = 2'b10;
    do_frame(2'b10, 2'b01, 2'b01, 1'b0, 16'h5A5A, 24, 0, "R2 match strap 10");
    do_frame(2'b00, 2'b01, 2'b01, 1'b0, 16'h0F0F, 24, 0, "R2 old address");

    // R7 short frames discarded, next frame normal
    do_frame(2'b10, 2'b01, 2'b10, 1'b0, 16'hBEEF, 12, 0, "R7 short 12");
    do_frame(2'b10, 2'b01, 2'b10, 1'b0, 16'hBEEF, 23, 0, "R7 short 23");
    do_frame(2'b10, 2'b01, 2'b10, 1'b0, 16'h1234, 24, 0, "R7 recover");

    // R8 reserved mode and power-down bit
    do_frame(2'b10, 2'b11, 2'b00, 1'b0, 16'h9999, 24, 0, "R8 mode 11");
    do_frame(2'b10, 2'b01, 2'b00, 1'b1, 16'h8888, 24, 0, "R8 power-down bit");

    // R11 extra clocks after 24 bits ignored
    do_frame(2'b10, 2'b01, 2'b11, 1'b0, 16'h0042, 24, 6, "R11 long frame");

    // R5 with one staging register out of step with its live value
    do_frame(2'b10, 2'b00, 2'b00, 1'b0, 16'h7777, 24, 0, "R3 stage ch0 again");
    do_frame(2'b10, 2'b10, 2'b10, 1'b0, 16'h6666, 24, 0, "R5 mixed load all");

    // R10 reset in the middle of operation
    apply_reset("R10 mid reset");
    do_frame(2'b10, 2'b10, 2'b01, 1'b0, 16'hCAFE, 24, 0, "R5 R10 after reset");

    finish_sim();
  end
endmodule